// File: doc/BRIEF.md
# PC Card Host Cycle Decoder

This block sits behind the host connector of a 16-bit PC Card style I/O card. The host strobes arrive already synchronised to the core clock. On every clock edge the block samples the host address, data, the two card enables, the register-space select and the four strobes. It then classifies the cycle as an I/O register access, an attribute memory access or nothing. The card has no common memory, so a cycle that does not assert the register-space select never does anything.

For an accepted cycle the block reports which byte lanes take part and whether the access is a full word. It also reports whether an odd byte arrived on the low data lines. It gives the register index for I/O cycles or the attribute word address for attribute cycles, and passes on the write data steered onto its internal lanes. It also drives the active-low input-acknowledge pin for valid I/O reads.

I/O register cycles are refused until firmware raises the I/O-mode flag. Attribute cycles are not gated by that flag. A mask and a base value, both configurable, decide which of the four upper address bits take part in I/O decoding. With the mask at zero, all four are ignored.

Top module: `pccard_cycle_decoder`

## Requirements
- R1: While reset is asserted and after it is released with no cycle applied, the cycle kind is 0 (none), both lane enables are 0, the index, attribute address, data and flags are 0, and the acknowledge output is high.
- R2: A cycle sampled with the register-space select high (inactive) gives cycle kind 0, no lanes and a high acknowledge, whatever the strobes and enables are.
- R3: A cycle sampled with both card enables high gives cycle kind 0.
- R4: For I/O cycles the lane pattern is decoded from {ce1_n, ce2_n, addr[0]}. 000 is a word with lanes 2'b11. 010 is the even byte with lanes 2'b01. 011 is the odd byte carried on the low data lines, with lanes 2'b10 and the swap flag set. 10x is the odd byte on the high lines, with lanes 2'b10 and no swap. 001 is invalid and the cycle is ignored. Lane bit 0 is the even byte, bit 1 the odd byte.
- R5: An I/O cycle sampled while io_mode is low gives cycle kind 0.
- R6: An accepted I/O cycle gives cycle kind 1 and a register index equal to addr[5:0]. With the mask at 0, addr[9:6] have no effect.
- R7: For each set bit k of the 4-bit mask, addr[6+k] must equal bit k of the base value, or the I/O cycle is ignored.
- R8: An attribute cycle (read or write strobe of attribute space) is accepted only when ce1_n is low and addr[0] is 0, whatever ce2_n and io_mode are. It gives cycle kind 2, lanes 2'b01, no word flag, no swap, and an attribute address equal to addr[9:1]. Otherwise it is ignored.
- R9: A cycle is considered only when exactly one of the four strobes (I/O read, I/O write, attribute read, attribute write) is low. With none or several low it is ignored.
- R10: The acknowledge output is low exactly in the cycle after an accepted I/O read was sampled.
- R11: The data output carries the host low byte in bits 7:0 when lane 0 is enabled. Bits 15:8 carry the odd byte when lane 1 is enabled, taken from the host low lines when swap is set and from the high lines otherwise. Lanes not enabled read 0.
- R12: The write flag is 1 for accepted I/O writes and attribute writes, and 0 for accepted reads and ignored cycles.
- R13: All outputs change exactly one clock edge after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 10 | Host address lines |
| host_data | input | 16 | Host write data lines |
| ce1_n | input | 1 | Even-byte card enable, active low |
| ce2_n | input | 1 | Odd-byte card enable, active low |
| reg_n | input | 1 | Register-space select, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| oe_n | input | 1 | Attribute read strobe, active low |
| we_n | input | 1 | Attribute write strobe, active low |
| io_mode | input | 1 | High once initialisation is done and I/O mode is on |
| addr_mask | input | 4 | Selects which of addr[9:6] are compared |
| io_base | input | 4 | Compare value for the masked upper address bits |
| cyc_kind | output | 2 | 0 none, 1 I/O register, 2 attribute |
| cyc_write | output | 1 | Accepted cycle is a write |
| lane_en | output | 2 | Byte lanes taking part (bit 0 even, bit 1 odd) |
| is_word | output | 1 | Accepted I/O word access |
| odd_on_low | output | 1 | Odd byte arrived on the low data lines |
| reg_idx | output | 6 | I/O register byte index |
| attr_addr | output | 9 | Attribute word address |
| lane_data | output | 16 | Write data steered onto internal lanes |
| inpack_n | output | 1 | Input acknowledge, active low |

## Verification
The bench sweeps every combination of the two enables, addr[0], register select, all sixteen strobe patterns and io_mode. It runs this sweep for six address values under three mask/base settings and predicts each output arithmetically from the requirement rules. The sweep separates the lane table cells from each other and the invalid word-at-odd-address cell from the valid ones. It also separates conflicting or missing strobes from single strobes, and I/O gating by io_mode from attribute cycles that ignore it. The address values place ones and zeros in every upper bit, so a masked bit that mismatches the base is told apart from one that matches and from an unmasked bit that is free to vary.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_IO   = 2'd1,
    CYC_ATTR = 2'd2
  } cyc_kind_e;

  typedef struct packed {
    logic [1:0] lanes;
    logic       word;
    logic       swap;
    logic       ok;
  } lane_sel_t;

endpackage

// File: rtl/pcd_lane_decode.sv
module pcd_lane_decode
  import pcd_pkg::*;
(
  input  logic      ce1_n,
  input  logic      ce2_n,
  input  logic      a0,
  output lane_sel_t sel
);

  always_comb begin
    sel = '0;
    unique case ({ce1_n, ce2_n, a0})
      3'b000: begin
        sel.lanes = 2'b11;
        sel.word  = 1'b1;
        sel.ok    = 1'b1;
      end
      3'b010: begin
        sel.lanes = 2'b01;
        sel.ok    = 1'b1;
      end
      3'b011: begin
        sel.lanes = 2'b10;
        sel.swap  = 1'b1;
        sel.ok    = 1'b1;
      end
      3'b100, 3'b101: begin
        sel.lanes = 2'b10;
        sel.ok    = 1'b1;
      end
      default: sel = '0;
    endcase
  end

endmodule

// File: rtl/pcd_io_match.sv
module pcd_io_match #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6,
  localparam int UPPER_W = ADDR_W - IDX_W
) (
  input  logic [UPPER_W-1:0] upper_addr,
  input  logic [UPPER_W-1:0] mask,
  input  logic [UPPER_W-1:0] base,
  output logic               hit
);

  logic [UPPER_W-1:0] miss;

  for (genvar k = 0; k < UPPER_W; k++) begin : g_bit
    assign miss[k] = mask[k] & (upper_addr[k] ^ base[k]);
  end

  assign hit = ~|miss;

endmodule

// File: rtl/pcd_classify.sv
module pcd_classify
  import pcd_pkg::*;
(
  input  logic      reg_n,
  input  logic      ce1_n,
  input  logic      ce2_n,
  input  logic      a0,
  input  logic      iord_n,
  input  logic      iowr_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      io_mode,
  input  logic      io_hit,
  input  logic      lanes_ok,
  output cyc_kind_e kind,
  output logic      is_write
);

  logic [3:0] strobe_act;
  logic       one_strobe;
  logic       card_sel;
  logic       io_strobe;
  logic       attr_strobe;

  assign strobe_act  = {~we_n, ~oe_n, ~iowr_n, ~iord_n};
  assign one_strobe  = (strobe_act != 4'b0000) &&
                       ((strobe_act & (strobe_act - 4'd1)) == 4'b0000);
  assign card_sel    = ~reg_n & ~(ce1_n & ce2_n);
  assign io_strobe   = strobe_act[0] | strobe_act[1];
  assign attr_strobe = strobe_act[2] | strobe_act[3];

  always_comb begin
    kind     = CYC_NONE;
    is_write = 1'b0;
    if (card_sel && one_strobe) begin
      if (io_strobe) begin
        if (io_mode && io_hit && lanes_ok) begin
          kind     = CYC_IO;
          is_write = strobe_act[1];
        end
      end else if (attr_strobe) begin
        if (!ce1_n && !a0) begin
          kind     = CYC_ATTR;
          is_write = strobe_act[3];
        end
      end
    end
  end

endmodule

// File: rtl/pcd_data_steer.sv
module pcd_data_steer #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  lanes,
  input  logic              swap,
  output logic [DATA_W-1:0] dout
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] src;
    if (l == 0) begin : g_low
      assign src = din[7:0];
    end else begin : g_high
      assign src = swap ? din[7:0] : din[8*l +: 8];
    end
    assign dout[8*l +: 8] = lanes[l] ? src : 8'h00;
  end

endmodule

// File: rtl/pccard_cycle_decoder.sv
module pccard_cycle_decoder
  import pcd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  localparam int UPPER_W = ADDR_W - IDX_W,
  localparam int ATTR_W  = ADDR_W - 1,
  localparam int LANES   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              ce1_n,
  input  logic              ce2_n,
  input  logic              reg_n,
  input  logic              iord_n,
  input  logic              iowr_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              io_mode,
  input  logic [UPPER_W-1:0] addr_mask,
  input  logic [UPPER_W-1:0] io_base,
  output logic [1:0]        cyc_kind,
  output logic              cyc_write,
  output logic [LANES-1:0]  lane_en,
  output logic              is_word,
  output logic              odd_on_low,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [ATTR_W-1:0] attr_addr,
  output logic [DATA_W-1:0] lane_data,
  output logic              inpack_n
);

  lane_sel_t  sel;
  logic       io_hit;
  cyc_kind_e  kind_c;
  logic       wr_c;

  pcd_lane_decode u_lane (
    .ce1_n (ce1_n),
    .ce2_n (ce2_n),
    .a0    (host_addr[0]),
    .sel   (sel)
  );

  pcd_io_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .upper_addr (host_addr[ADDR_W-1:IDX_W]),
    .mask       (addr_mask),
    .base       (io_base),
    .hit        (io_hit)
  );

  pcd_classify u_class (
    .reg_n    (reg_n),
    .ce1_n    (ce1_n),
    .ce2_n    (ce2_n),
    .a0       (host_addr[0]),
    .iord_n   (iord_n),
    .iowr_n   (iowr_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .io_mode  (io_mode),
    .io_hit   (io_hit),
    .lanes_ok (sel.ok),
    .kind     (kind_c),
    .is_write (wr_c)
  );

  // next-state values
  logic [1:0]        kind_d;
  logic              wr_d;
  logic [LANES-1:0]  lane_d;
  logic              word_d;
  logic              swap_d;
  logic [IDX_W-1:0]  idx_d;
  logic [ATTR_W-1:0] attr_d;
  logic [DATA_W-1:0] data_d;
  logic              ack_d;

  always_comb begin
    kind_d = kind_c;
    wr_d   = wr_c;
    lane_d = '0;
    word_d = 1'b0;
    swap_d = 1'b0;
    idx_d  = '0;
    attr_d = '0;
    ack_d  = 1'b1;
    unique case (kind_c)
      CYC_IO: begin
        lane_d = sel.lanes;
        word_d = sel.word;
        swap_d = sel.swap;
        idx_d  = host_addr[IDX_W-1:0];
        ack_d  = wr_c;
      end
      CYC_ATTR: begin
        lane_d = {{(LANES-1){1'b0}}, 1'b1};
        attr_d = host_addr[ADDR_W-1:1];
      end
      default: ;
    endcase
  end

  pcd_data_steer #(.DATA_W(DATA_W)) u_steer (
    .din   (host_data),
    .lanes (lane_d),
    .swap  (swap_d),
    .dout  (data_d)
  );

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_kind   <= CYC_NONE;
      cyc_write  <= 1'b0;
      lane_en    <= '0;
      is_word    <= 1'b0;
      odd_on_low <= 1'b0;
      reg_idx    <= '0;
      attr_addr  <= '0;
      lane_data  <= '0;
      inpack_n   <= 1'b1;
    end else begin
      cyc_kind   <= kind_d;
      cyc_write  <= wr_d;
      lane_en    <= lane_d;
      is_word    <= word_d;
      odd_on_low <= swap_d;
      reg_idx    <= idx_d;
      attr_addr  <= attr_d;
      lane_data  <= data_d;
      inpack_n   <= ack_d;
    end
  end

endmodule

// File: rtl/pccard_cycle_decoder_chk.sv
module pccard_cycle_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce1_n,
  input logic       ce2_n,
  input logic       reg_n,
  input logic       iord_n,
  input logic       iowr_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       io_mode,
  input logic [1:0] cyc_kind,
  input logic       cyc_write,
  input logic [1:0] lane_en,
  input logic       inpack_n
);

  p_noreg_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_n |=> (cyc_kind == 2'd0 && inpack_n));

  p_noce_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && ce2_n) |=> (cyc_kind == 2'd0));

  p_io_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !io_mode |=> (cyc_kind != 2'd1));

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({iord_n, iowr_n, oe_n, we_n}) != 3) |=> (cyc_kind == 2'd0));

  p_ack_io_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inpack_n |-> (cyc_kind == 2'd1 && !cyc_write));

  p_attr_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 2'd2) |-> (lane_en == 2'b01));

  p_lanes_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind != 2'd0) |-> (lane_en != 2'b00));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 2'd0) |-> (!cyc_write && lane_en == 2'b00));

endmodule

bind pccard_cycle_decoder pccard_cycle_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce1_n     (ce1_n),
  .ce2_n     (ce2_n),
  .reg_n     (reg_n),
  .iord_n    (iord_n),
  .iowr_n    (iowr_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .io_mode   (io_mode),
  .cyc_kind  (cyc_kind),
  .cyc_write (cyc_write),
  .lane_en   (lane_en),
  .inpack_n  (inpack_n)
);

// File: tb/pccard_cycle_decoder_test.sv
module pccard_cycle_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  host_addr;
  logic [15:0] host_data;
  logic        ce1_n, ce2_n, reg_n, iord_n, iowr_n, oe_n, we_n, io_mode;
  logic [3:0]  addr_mask, io_base;
  logic [1:0]  cyc_kind;
  logic        cyc_write;
  logic [1:0]  lane_en;
  logic        is_word, odd_on_low;
  logic [5:0]  reg_idx;
  logic [8:0]  attr_addr;
  logic [15:0] lane_data;
  logic        inpack_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pccard_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_data(host_data),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n), .iord_n(iord_n),
    .iowr_n(iowr_n), .oe_n(oe_n), .we_n(we_n), .io_mode(io_mode),
    .addr_mask(addr_mask), .io_base(io_base), .cyc_kind(cyc_kind),
    .cyc_write(cyc_write), .lane_en(lane_en), .is_word(is_word),
    .odd_on_low(odd_on_low), .reg_idx(reg_idx), .attr_addr(attr_addr),
    .lane_data(lane_data), .inpack_n(inpack_n)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected values, derived from the requirement text
  logic [1:0]  e_kind, e_lane;
  logic        e_wr, e_word, e_swap, e_ack;
  logic [5:0]  e_idx;
  logic [8:0]  e_attr;
  logic [15:0] e_data;
  string       e_req;

  task automatic predict();
    int nlow;
    logic io_s, at_s, hit;
    nlow = 4 - (iord_n + iowr_n + oe_n + we_n);
    io_s = !iord_n || !iowr_n;
    at_s = !oe_n || !we_n;
    hit  = 1'b1;
    for (int k = 0; k < 4; k++)
      if (addr_mask[k] && host_addr[6+k] != io_base[k]) hit = 1'b0;
    e_kind = 0; e_lane = 0; e_wr = 0; e_word = 0; e_swap = 0;
    e_idx = 0; e_attr = 0; e_ack = 1;
    if (reg_n)                 e_req = "R2";
    else if (ce1_n && ce2_n)   e_req = "R3";
    else if (nlow != 1)        e_req = "R9";
    else if (io_s) begin
      if (!ce1_n && !ce2_n && host_addr[0]) e_req = "R4";
      else if (!io_mode)       e_req = "R5";
      else if (!hit)           e_req = "R7";
      else begin
        e_req  = "R6";
        e_kind = 1;
        e_wr   = !iowr_n;
        e_idx  = host_addr[5:0];
        e_ack  = e_wr;
        if (!ce1_n && !ce2_n) begin e_lane = 2'b11; e_word = 1; end
        else if (!ce1_n && !host_addr[0]) e_lane = 2'b01;
        else if (!ce1_n) begin e_lane = 2'b10; e_swap = 1; end
        else e_lane = 2'b10;
      end
    end else begin
      e_req = "R8";
      if (at_s && !ce1_n && !host_addr[0]) begin
        e_kind = 2;
        e_wr   = !we_n;
        e_lane = 2'b01;
        e_attr = host_addr[9:1];
      end
    end
    e_data[7:0]  = e_lane[0] ? host_data[7:0] : 8'h00;
    e_data[15:8] = e_lane[1] ? (e_swap ? host_data[7:0] : host_data[15:8]) : 8'h00;
  endtask

  task automatic compare_all();
    check(e_req, "kind",   cyc_kind,   e_kind);
    check("R4",  "lanes",  lane_en,    e_lane);
    check("R4",  "word",   is_word,    e_word);
    check("R4",  "swap",   odd_on_low, e_swap);
    check("R6",  "idx",    reg_idx,    e_idx);
    check("R8",  "attr",   attr_addr,  e_attr);
    check("R10", "ack",    inpack_n,   e_ack);
    check("R11", "data",   lane_data,  e_data);
    check("R12", "write",  cyc_write,  e_wr);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [9:0] ADDRS [6] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA, 10'h0C7, 10'h301};
  localparam logic [3:0] MASKS [3] = '{4'h0, 4'hF, 4'h9};
  localparam logic [3:0] BASES [3] = '{4'hA, 4'h5, 4'hC};

  initial begin
    rst_n = 1'b0;
    host_addr = '0; host_data = '0;
    ce1_n = 1; ce2_n = 1; reg_n = 1;
    iord_n = 1; iowr_n = 1; oe_n = 1; we_n = 1;
    io_mode = 0; addr_mask = 0; io_base = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset kind", cyc_kind, 0);
    check("R1", "reset ack", inpack_n, 1);
    check("R1", "reset lanes", lane_en, 0);
    check("R1", "reset data", lane_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "idle kind", cyc_kind, 0);
    check("R1", "idle ack", inpack_n, 1);

    for (int c = 0; c < 3; c++) begin
      for (int a = 0; a < 6; a++) begin
        for (int v = 0; v < 512; v++) begin
          @(negedge clk);
          addr_mask = MASKS[c];
          io_base   = BASES[c];
          host_addr = ADDRS[a] ^ {9'd0, v[0]};
          ce1_n     = v[1];
          ce2_n     = v[2];
          reg_n     = v[3];
          {we_n, oe_n, iowr_n, iord_n} = v[7:4];
          io_mode   = v[8];
          host_data = 16'hA5C3 ^ 16'(v * 16'h0101) ^ {6'd0, ADDRS[a]};
          predict();
          // R13: outputs valid one edge after sampling
          @(negedge clk);
          compare_all();
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule